// File: doc/BRIEF.md
# Branch and Call Target Generator

This combinational block works out the next program counter of an 8-bit microcontroller core from the address and bytes of the instruction being executed. It covers jumps and calls with 11-bit page-local targets, long jumps and calls with 16-bit targets, signed relative branches with 2-byte and 3-byte forms, the indirect jump through the accumulator plus the data pointer, the return instructions, and plain sequential fall-through. The instruction length is decoded from the opcode inside the block.

For calls the block produces two stack writes, each with its own address and data, and the new stack pointer. For returns it produces the two stack read addresses, takes the bytes read back, and lowers the stack pointer. The decision of whether a conditional branch is taken comes from outside on `taken_i`. The core's execute stage evaluates the condition and the block only picks the target.

Top module: `branch_target_gen`

## Requirements
- R1: An opcode whose low five bits are 00001 (jump) or 10001 (call) gives the target {PC+2 bits 15:11, opcode bits 7:5, byte1}. Example: opcode 0x71 at 0x0123 with byte1 0x45 goes to 0x0345.
- R2: Opcode 0x02 (long jump) and 0x12 (long call) give the target {byte1, byte2}.
- R3: Opcodes 0x80, 0x40, 0x50, 0x60, 0x70 and 0xD8-0xDF are two bytes long. When they branch, the target is PC+2 plus byte1 sign-extended.
- R4: Opcodes 0x10, 0x20, 0x30, 0xB4-0xBF and 0xD5 are three bytes long. When they branch, the target is PC+3 plus byte2 sign-extended.
- R5: Opcode 0x80 always branches. The other relative opcodes branch only when `taken_i` is 1, and otherwise fall through to PC plus their length. `taken_i` has no effect on any non-branch opcode.
- R6: Opcode 0x73 jumps to the zero-extended accumulator plus the data pointer.
- R7: The call opcodes (R1 call form, and 0x12) assert `push_en_o`. They write return-address bits 7:0 to SP+1 and bits 15:8 to SP+2, and set the new SP to SP+2. The return address is PC plus the instruction length.
- R8: Opcodes 0x22 and 0x32 assert `pop_en_o`. The high byte is read at SP and the low byte at SP-1, the next PC is {stk_hi_i, stk_lo_i}, and the new SP is SP-2.
- R9: Any other opcode advances the PC by its own length, which is 1, 2 or 3. Examples: 0x00, 0xE8 and 0xA5 are 1 byte; 0x24 is 2 bytes; 0x75, 0x85, 0x90 and 0xB6 are 3 bytes.
- R10: All PC arithmetic wraps modulo 2^PC_W, and all SP arithmetic wraps modulo 2^SP_W.
- R11: `push_en_o` and `pop_en_o` are never both high. When neither is high, the new SP equals `sp_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | PC_W | Address of the current instruction |
| opcode_i | input | 8 | First instruction byte |
| byte1_i | input | 8 | Second instruction byte |
| byte2_i | input | 8 | Third instruction byte |
| taken_i | input | 1 | Condition result for conditional branches |
| acc_i | input | 8 | Accumulator value |
| dptr_i | input | PC_W | Data pointer value |
| sp_i | input | SP_W | Current stack pointer |
| stk_hi_i | input | 8 | Byte read at the high pop address |
| stk_lo_i | input | 8 | Byte read at the low pop address |
| next_pc_o | output | PC_W | Next program counter |
| push_en_o | output | 1 | Call stack write pair valid |
| push_lo_addr_o | output | SP_W | Address of the first push |
| push_lo_data_o | output | 8 | Return address low byte |
| push_hi_addr_o | output | SP_W | Address of the second push |
| push_hi_data_o | output | 8 | Return address high byte |
| pop_en_o | output | 1 | Return stack read pair valid |
| pop_hi_addr_o | output | SP_W | Address of the high byte read |
| pop_lo_addr_o | output | SP_W | Address of the low byte read |
| sp_next_o | output | SP_W | Updated stack pointer |

## Verification
The bench builds the block with its defaults, PC_W=16 and SP_W=8. With these widths the wrap points are easy to reach: a 0xFFFx address, a stack pointer of 0xFF, and a page-local target whose incremented PC crosses into the next 2 KB page. Vectors place instructions so that each of these edges is hit, with both positive and negative offsets at the extremes of the signed range. The vectors also cover every length class of the fall-through decode.

// File: rtl/branch_target_gen.sv
module branch_target_gen #(
  parameter int PC_W = 16,
  parameter int SP_W = 8
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [7:0]      opcode_i,
  input  logic [7:0]      byte1_i,
  input  logic [7:0]      byte2_i,
  input  logic            taken_i,
  input  logic [7:0]      acc_i,
  input  logic [PC_W-1:0] dptr_i,
  input  logic [SP_W-1:0] sp_i,
  input  logic [7:0]      stk_hi_i,
  input  logic [7:0]      stk_lo_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic            push_en_o,
  output logic [SP_W-1:0] push_lo_addr_o,
  output logic [7:0]      push_lo_data_o,
  output logic [SP_W-1:0] push_hi_addr_o,
  output logic [7:0]      push_hi_data_o,
  output logic            pop_en_o,
  output logic [SP_W-1:0] pop_hi_addr_o,
  output logic [SP_W-1:0] pop_lo_addr_o,
  output logic [SP_W-1:0] sp_next_o
);
  localparam int PAGE_W = 11;
  localparam int EXT_W  = PC_W - 8;

  function automatic logic [1:0] op_len(input logic [7:0] op);
    logic [3:0] hi;
    hi = op[7:4];
    op_len = 2'd1;
    case (op[3:0])
      4'h0: case (hi)
              4'h0, 4'hE, 4'hF:       op_len = 2'd1;
              4'h1, 4'h2, 4'h3, 4'h9: op_len = 2'd3;
              default:                op_len = 2'd2;
            endcase
      4'h1: op_len = 2'd2;
      4'h2: case (hi)
              4'h0, 4'h1:             op_len = 2'd3;
              4'h2, 4'h3, 4'hE, 4'hF: op_len = 2'd1;
              default:                op_len = 2'd2;
            endcase
      4'h3: case (hi)
              4'h4, 4'h5, 4'h6: op_len = 2'd3;
              default:          op_len = 2'd1;
            endcase
      4'h4: case (hi)
              4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h9: op_len = 2'd2;
              4'hB:                                     op_len = 2'd3;
              default:                                  op_len = 2'd1;
            endcase
      4'h5: case (hi)
              4'h7, 4'h8, 4'hB, 4'hD: op_len = 2'd3;
              4'hA:                   op_len = 2'd1;
              default:                op_len = 2'd2;
            endcase
      default: case (hi)
              4'h7, 4'h8, 4'hA: op_len = 2'd2;
              4'hB:             op_len = 2'd3;
              4'hD:             op_len = op[3] ? 2'd2 : 2'd1;
              default:          op_len = 2'd1;
            endcase
    endcase
  endfunction

  logic [1:0]      len;
  logic [PC_W-1:0] seq_pc, abs_pc, long_pc, ind_pc, rel_pc, ret_pc;
  logic [7:0]      rel_off;
  logic            is_abs, is_call, is_long, is_ind, is_ret, is_rel2, is_rel3, go;

  assign len     = op_len(opcode_i);
  assign seq_pc  = pc_i + PC_W'(len);

  assign is_abs  = opcode_i[3:0] == 4'h1;
  assign is_long = opcode_i == 8'h02 || opcode_i == 8'h12;
  assign is_call = (is_abs && opcode_i[4]) || opcode_i == 8'h12;
  assign is_ind  = opcode_i == 8'h73;
  assign is_ret  = opcode_i == 8'h22 || opcode_i == 8'h32;
  assign is_rel2 = opcode_i == 8'h80 || opcode_i == 8'h40 || opcode_i == 8'h50 ||
                   opcode_i == 8'h60 || opcode_i == 8'h70 || opcode_i[7:3] == 5'b11011;
  assign is_rel3 = opcode_i == 8'h10 || opcode_i == 8'h20 || opcode_i == 8'h30 ||
                   (opcode_i[7:4] == 4'hB && opcode_i[3:2] != 2'b00) || opcode_i == 8'hD5;
  assign go      = opcode_i == 8'h80 || taken_i;

  assign rel_off = is_rel3 ? byte2_i : byte1_i;
  assign rel_pc  = seq_pc + {{EXT_W{rel_off[7]}}, rel_off};
  assign abs_pc  = {seq_pc[PC_W-1:PAGE_W], opcode_i[7:5], byte1_i};
  assign long_pc = PC_W'({byte1_i, byte2_i});
  assign ind_pc  = PC_W'(acc_i) + dptr_i;
  assign ret_pc  = PC_W'({stk_hi_i, stk_lo_i});

  always_comb begin
    if (is_ret)                     next_pc_o = ret_pc;
    else if (is_abs)                next_pc_o = abs_pc;
    else if (is_long)               next_pc_o = long_pc;
    else if (is_ind)                next_pc_o = ind_pc;
    else if ((is_rel2 || is_rel3) && go) next_pc_o = rel_pc;
    else                            next_pc_o = seq_pc;
  end

  assign push_en_o      = is_call;
  assign push_lo_addr_o = sp_i + SP_W'(1);
  assign push_hi_addr_o = sp_i + SP_W'(2);
  assign push_lo_data_o = seq_pc[7:0];
  assign push_hi_data_o = seq_pc[15:8];
  assign pop_en_o       = is_ret;
  assign pop_hi_addr_o  = sp_i;
  assign pop_lo_addr_o  = sp_i - SP_W'(1);
  assign sp_next_o      = is_call ? push_hi_addr_o :
                          is_ret  ? sp_i - SP_W'(2) : sp_i;
endmodule

// File: rtl/branch_target_gen_chk.sv
module branch_target_gen_chk #(
  parameter int PC_W = 16,
  parameter int SP_W = 8
) (
  input logic [PC_W-1:0] pc_i,
  input logic [7:0]      opcode_i,
  input logic [SP_W-1:0] sp_i,
  input logic            push_en_o,
  input logic [SP_W-1:0] push_lo_addr_o,
  input logic [SP_W-1:0] push_hi_addr_o,
  input logic            pop_en_o,
  input logic [SP_W-1:0] pop_hi_addr_o,
  input logic [SP_W-1:0] pop_lo_addr_o,
  input logic [SP_W-1:0] sp_next_o,
  input logic [PC_W-1:0] next_pc_o
);
  logic [PC_W-1:0] pc2;
  assign pc2 = pc_i + PC_W'(2);

  always_comb begin
    if (!$isunknown({opcode_i, pc_i, sp_i, push_en_o, pop_en_o, sp_next_o,
                     push_lo_addr_o, push_hi_addr_o, pop_hi_addr_o, pop_lo_addr_o, next_pc_o})) begin
      a_r11_push_pop_exclusive: assert (!(push_en_o && pop_en_o));
      a_r11_sp_hold: assert (push_en_o || pop_en_o || sp_next_o == sp_i);
      a_r7_push_order: assert (!push_en_o ||
        (push_hi_addr_o == push_lo_addr_o + SP_W'(1) && sp_next_o == push_hi_addr_o));
      a_r7_push_only_calls: assert (!push_en_o ||
        opcode_i[4:0] == 5'b10001 || opcode_i == 8'h12);
      a_r8_pop_order: assert (!pop_en_o ||
        (pop_lo_addr_o == pop_hi_addr_o - SP_W'(1) && sp_next_o == pop_lo_addr_o - SP_W'(1)));
      a_r1_same_page: assert (opcode_i[3:0] != 4'h1 ||
        (next_pc_o[PC_W-1:11] == pc2[PC_W-1:11] && next_pc_o[10:8] == opcode_i[7:5]));
    end
  end
endmodule

bind branch_target_gen branch_target_gen_chk #(.PC_W(PC_W), .SP_W(SP_W)) u_chk (.*);

// File: tb/branch_target_gen_tb.sv
module branch_target_gen_tb;
  localparam int PC_W = 16;
  localparam int SP_W = 8;
  localparam int NV   = 28;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [PC_W-1:0] pc_i, dptr_i, next_pc_o;
  logic [7:0] opcode_i, byte1_i, byte2_i, acc_i, stk_hi_i, stk_lo_i;
  logic taken_i, push_en_o, pop_en_o;
  logic [SP_W-1:0] sp_i, push_lo_addr_o, push_hi_addr_o, pop_hi_addr_o, pop_lo_addr_o, sp_next_o;
  logic [7:0] push_lo_data_o, push_hi_data_o;

  branch_target_gen #(.PC_W(PC_W), .SP_W(SP_W)) u_dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // req, pc, opcode, byte1, byte2, taken, acc, dptr, sp, expected pc, expected sp
  localparam logic [100:0] VECS [NV] = '{
    {4'd1,  16'h0123, 8'h71, 8'h45, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h07, 16'h0345, 8'h09}, // R1 call
    {4'd1,  16'h0345, 8'h21, 8'h23, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h07, 16'h0123, 8'h07}, // R1 jump
    {4'd1,  16'h07FE, 8'h01, 8'h10, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0810, 8'h20}, // R1 page cross
    {4'd10, 16'hFFFE, 8'hE1, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0700, 8'h20}, // R10
    {4'd2,  16'h1000, 8'h02, 8'hAB, 8'hCD, 1'b0, 8'h00, 16'h0000, 8'h20, 16'hABCD, 8'h20}, // R2
    {4'd2,  16'h2000, 8'h12, 8'h12, 8'h34, 1'b0, 8'h00, 16'h0000, 8'h30, 16'h1234, 8'h32}, // R2
    {4'd3,  16'h0100, 8'h80, 8'hFE, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0100, 8'h20}, // R3
    {4'd3,  16'h0200, 8'h60, 8'h10, 8'h00, 1'b1, 8'h00, 16'h0000, 8'h20, 16'h0212, 8'h20}, // R3
    {4'd5,  16'h0200, 8'h60, 8'h10, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0202, 8'h20}, // R5
    {4'd3,  16'h0400, 8'hD8, 8'h7F, 8'h00, 1'b1, 8'h00, 16'h0000, 8'h20, 16'h0481, 8'h20}, // R3
    {4'd4,  16'h0300, 8'hB4, 8'h55, 8'h80, 1'b1, 8'h00, 16'h0000, 8'h20, 16'h0283, 8'h20}, // R4
    {4'd4,  16'h0500, 8'hD5, 8'h22, 8'hF0, 1'b1, 8'h00, 16'h0000, 8'h20, 16'h04F3, 8'h20}, // R4
    {4'd5,  16'h0500, 8'hD5, 8'h22, 8'hF0, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0503, 8'h20}, // R5
    {4'd10, 16'hFFF0, 8'h20, 8'h07, 8'h20, 1'b1, 8'h00, 16'h0000, 8'h20, 16'h0013, 8'h20}, // R10
    {4'd6,  16'h0000, 8'h73, 8'h00, 8'h00, 1'b0, 8'h10, 16'hFFF8, 8'h20, 16'h0008, 8'h20}, // R6
    {4'd6,  16'h1234, 8'h73, 8'h00, 8'h00, 1'b1, 8'hF0, 16'h1000, 8'h20, 16'h10F0, 8'h20}, // R6
    {4'd8,  16'h0600, 8'h22, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h09, 16'h0125, 8'h07}, // R8
    {4'd8,  16'h0600, 8'h32, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h01, 16'h0125, 8'hFF}, // R8
    {4'd9,  16'h0010, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0011, 8'h20}, // R9
    {4'd9,  16'h0010, 8'h75, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0013, 8'h20}, // R9
    {4'd5,  16'h0010, 8'h24, 8'h00, 8'h00, 1'b1, 8'h00, 16'h0000, 8'h20, 16'h0012, 8'h20}, // R5
    {4'd9,  16'h0010, 8'hE8, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0011, 8'h20}, // R9
    {4'd9,  16'h0010, 8'hB6, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0013, 8'h20}, // R9
    {4'd9,  16'h0010, 8'h85, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0013, 8'h20}, // R9
    {4'd9,  16'h0010, 8'hA5, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0011, 8'h20}, // R9
    {4'd9,  16'h0010, 8'h90, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0013, 8'h20}, // R9
    {4'd10, 16'hFFFF, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h20, 16'h0000, 8'h20}, // R10
    {4'd2,  16'hFFFE, 8'h12, 8'h00, 8'h10, 1'b0, 8'h00, 16'h0000, 8'hFF, 16'h0010, 8'h01}  // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [PC_W-1:0] pc, input logic [7:0] op, b1, b2,
                       input logic tk, input logic [7:0] a, input logic [PC_W-1:0] dp,
                       input logic [SP_W-1:0] sp);
    @(negedge clk);
    pc_i = pc; opcode_i = op; byte1_i = b1; byte2_i = b2;
    taken_i = tk; acc_i = a; dptr_i = dp; sp_i = sp;
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [3:0] r;
    logic [PC_W-1:0] pc, dp, epc;
    logic [7:0] op, b1, b2, a;
    logic tk;
    logic [SP_W-1:0] sp, esp;
    stk_hi_i = 8'h01;
    stk_lo_i = 8'h25;

    // R9 R11 start state: plain opcode, no stack activity
    apply(16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h40);
    chk("R9 start next pc", 32'(next_pc_o), 32'h0001);
    chk("R11 start push/pop", {30'd0, push_en_o, pop_en_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      {r, pc, op, b1, b2, tk, a, dp, sp, epc, esp} = VECS[i];
      apply(pc, op, b1, b2, tk, a, dp, sp);
      chk($sformatf("R%0d vector %0d next pc", r, i), 32'(next_pc_o), 32'(epc));
      chk($sformatf("R%0d vector %0d new sp", r, i), 32'(sp_next_o), 32'(esp));
    end

    // R7 page-local call: return 0x0125, low byte first
    apply(16'h0123, 8'h71, 8'h45, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h07);
    chk("R7 push enable", 32'(push_en_o), 32'h1);
    chk("R7 first push addr", 32'(push_lo_addr_o), 32'h08);
    chk("R7 first push data", 32'(push_lo_data_o), 32'h25);
    chk("R7 second push addr", 32'(push_hi_addr_o), 32'h09);
    chk("R7 second push data", 32'(push_hi_data_o), 32'h01);

    // R7 long call: return 0x2003
    apply(16'h2000, 8'h12, 8'h12, 8'h34, 1'b0, 8'h00, 16'h0000, 8'h30);
    chk("R7 long call lo data", 32'(push_lo_data_o), 32'h03);
    chk("R7 long call hi data", 32'(push_hi_data_o), 32'h20);
    chk("R7 long call hi addr", 32'(push_hi_addr_o), 32'h32);

    // R10 stack pointer wraps during a call
    apply(16'h0100, 8'h11, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'hFF);
    chk("R10 wrap push lo addr", 32'(push_lo_addr_o), 32'h00);
    chk("R10 wrap push hi addr", 32'(push_hi_addr_o), 32'h01);
    chk("R10 wrap new sp", 32'(sp_next_o), 32'h01);
    chk("R10 wrap target", 32'(next_pc_o), 32'h0000);

    // R8 return reads SP then SP-1
    apply(16'h0600, 8'h22, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h09);
    chk("R8 pop enable", {30'd0, push_en_o, pop_en_o}, 32'h1);
    chk("R8 pop hi addr", 32'(pop_hi_addr_o), 32'h09);
    chk("R8 pop lo addr", 32'(pop_lo_addr_o), 32'h08);

    // R11 non-control opcode with taken set touches no stack
    apply(16'h0010, 8'h24, 8'h00, 8'h00, 1'b1, 8'h00, 16'h0000, 8'h55);
    chk("R11 idle push/pop", {30'd0, push_en_o, pop_en_o}, 32'h0);
    chk("R11 idle sp", 32'(sp_next_o), 32'h55);

    finish_run();
  end
endmodule